// File: doc/BRIEF.md
# Single-Master Bus Fan-Out with Register Slaves

This block links one bus master to a set of register slaves over a simple synchronous bus that has no wait states. In cycle 1 the master presents an address, a write strobe, write data and a read strobe, all valid at one rising clock edge. For a read, the data comes back after that edge and is sampled at the following edge. The bus has no acknowledge or wait signal, so every access takes a fixed number of cycles.

The upper address bits select a window. Each window is a power-of-two aligned slave region. The decoder forwards the write and read strobes only to the slave that owns the window. All slaves receive the same lower address bits and write data. Every slave that is not reading drives zeros, so the read data returned to the master is a plain bitwise OR of all slave outputs. No read multiplexer is needed.

With default parameters the address is 8 bits wide. There are four windows of 64 locations each. Slaves 0 to 2 each hold sixteen 16-bit registers, and window 3 has no slave.

Top module: `sbus_fanout`

## Requirements
- R1: Reset is synchronous and active high. After reset every register of every slave reads 0, and `m_rdata` is 0.
- R2: A write strobe with address bits [7:6] = k (where k < NUM_SLV) and bits [5:4] = 0 stores `m_wdata` into register `m_addr[3:0]` of slave k.
- R3: A read strobe sampled at clock edge E makes `m_rdata` carry the addressed register after E, so the master samples it at edge E+1. Reads in consecutive cycles each return their own value.
- R4: In any cycle that follows an edge with no read strobe, `m_rdata` is all zeros.
- R5: An address whose window bits [7:6] are NUM_SLV or higher (window 3 by default) is unmapped. A write there changes no register, and a read there returns 0.
- R6: An address whose local bits [5:4] are nonzero lies beyond the register depth of the slave. A write there has no effect, and a read there returns 0.
- R7: When write and read strobes are asserted in the same cycle, the read returns the register value from before that edge, and the new value is stored.
- R8: Strobes presented while reset is high are not forwarded. A write attempted during reset leaves the register at 0.
- R9: The same local register index in different slaves holds independent values.
- R10: At most one slave drives nonzero read data at any time, and `m_rdata` is the bitwise OR of all slave outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| m_addr | input | ADDR_W (8) | Master address: [7:6] window, [5:0] slave-local |
| m_wr | input | 1 | Master write strobe |
| m_wdata | input | DATA_W (16) | Master write data |
| m_rd | input | 1 | Master read strobe |
| m_rdata | output | DATA_W (16) | OR-merged read data, valid one cycle after the read strobe |

## Verification
The hardest case to reach is a write and a read to the same register in one cycle while that register already holds a known nonzero value. The read must return the old contents, not the value being written. The stimulus first fills every register with a distinct value and then issues combined write-read strobes to those registers. A long pseudo-random run then mixes unmapped windows, out-of-depth local addresses and combined strobes. The bench's model tracks every register, so that a stray write shows up on a later read.

// File: rtl/sbus_pkg.sv
package sbus_pkg;

    // Access kind seen by a slave in one cycle, encoded as {rd, wr}.
    typedef enum logic [1:0] {
        ACC_IDLE  = 2'b00,
        ACC_WRITE = 2'b01,
        ACC_READ  = 2'b10,
        ACC_BOTH  = 2'b11
    } acc_e;

    function automatic acc_e acc_kind(input logic wr, input logic rd);
        return acc_e'({rd, wr});
    endfunction

endpackage

// File: rtl/sbus_decode.sv
module sbus_decode #(
    parameter int ADDR_W  = 8,
    parameter int DATA_W  = 16,
    parameter int SEL_W   = 2,
    parameter int NUM_SLV = 3,
    localparam int LOC_W  = ADDR_W - SEL_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [ADDR_W-1:0]  m_addr,
    input  logic               m_wr,
    input  logic               m_rd,
    input  logic [DATA_W-1:0]  m_wdata,
    output logic [NUM_SLV-1:0] s_wr,
    output logic [NUM_SLV-1:0] s_rd,
    output logic [LOC_W-1:0]   s_addr,
    output logic [DATA_W-1:0]  s_wdata
);
    localparam logic [SEL_W:0] NSLV_L = (SEL_W+1)'(NUM_SLV);

    logic [SEL_W-1:0] win;
    logic             mapped;

    assign win     = m_addr[ADDR_W-1 -: SEL_W];
    assign mapped  = {1'b0, win} < NSLV_L;
    assign s_addr  = m_addr[LOC_W-1:0];
    assign s_wdata = m_wdata;

    for (genvar k = 0; k < NUM_SLV; k++) begin : g_sel
        logic hit;
        assign hit     = (win == SEL_W'(k));
        assign s_wr[k] = !rst && m_wr && hit;
        assign s_rd[k] = !rst && m_rd && hit;
    end

    // R8: nothing leaves the decoder while reset is high
    a_r8_reset_quiet: assert property (@(posedge clk)
        rst |-> (s_wr == '0 && s_rd == '0));

    // R5: an unmapped window reaches no slave
    a_r5_unmapped_quiet: assert property (@(posedge clk) disable iff (rst)
        !mapped |-> (s_wr == '0 && s_rd == '0));

    // R10: at most one slave is selected per strobe
    a_r10_single_sel: assert property (@(posedge clk) disable iff (rst)
        $onehot0(s_wr) && $onehot0(s_rd));

    // R2: a mapped write always reaches exactly one slave
    a_r2_write_forwarded: assert property (@(posedge clk) disable iff (rst)
        (m_wr && mapped) |-> $countones(s_wr) == 1);

endmodule

// File: rtl/sbus_regslave.sv
module sbus_regslave
    import sbus_pkg::*;
#(
    parameter int LOC_W    = 6,
    parameter int DATA_W   = 16,
    parameter int DEPTH_AW = 4,
    localparam int DEPTH   = 1 << DEPTH_AW
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic              rd,
    input  logic [LOC_W-1:0]  addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0]   regs [DEPTH];
    logic [DATA_W-1:0]   rdata_q;
    logic [DEPTH_AW-1:0] idx;
    logic [DATA_W-1:0]   cur;
    logic                in_range;
    acc_e                kind;

    assign idx  = addr[DEPTH_AW-1:0];
    assign cur  = regs[idx];
    assign kind = acc_kind(wr && in_range, rd && in_range);

    if (LOC_W > DEPTH_AW) begin : g_hi
        assign in_range = ~|addr[LOC_W-1:DEPTH_AW];
    end else begin : g_full
        assign in_range = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) regs[i] <= '0;
            rdata_q <= '0;
        end else begin
            case (kind)
                ACC_WRITE: begin
                    regs[idx] <= wdata;
                    rdata_q   <= '0;
                end
                ACC_READ:  rdata_q <= cur;
                ACC_BOTH: begin
                    rdata_q   <= cur;
                    regs[idx] <= wdata;
                end
                default:   rdata_q <= '0;
            endcase
        end
    end

    assign rdata = rdata_q;

    // R4: a slave that did not read drives zeros
    a_r4_idle_zero: assert property (@(posedge clk) disable iff (rst)
        !rd |=> rdata == '0);

    // R6: beyond-depth read returns zeros
    a_r6_out_of_range: assert property (@(posedge clk) disable iff (rst)
        (rd && !in_range) |=> rdata == '0);

    // R7: combined strobes return the pre-write contents
    a_r7_read_old: assert property (@(posedge clk) disable iff (rst)
        (rd && wr && in_range) |=> rdata == $past(cur));

    // R3: a plain read returns the addressed register
    a_r3_read_value: assert property (@(posedge clk) disable iff (rst)
        (rd && in_range) |=> rdata == $past(cur));

endmodule

// File: rtl/sbus_or_combine.sv
module sbus_or_combine #(
    parameter int NUM_SLV = 3,
    parameter int DATA_W  = 16
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [NUM_SLV*DATA_W-1:0] slv_rdata,
    output logic [DATA_W-1:0]         merged
);
    logic [NUM_SLV-1:0] nz;

    for (genvar k = 0; k < NUM_SLV; k++) begin : g_nz
        assign nz[k] = |slv_rdata[k*DATA_W +: DATA_W];
    end

    always_comb begin
        merged = '0;
        for (int k = 0; k < NUM_SLV; k++) merged |= slv_rdata[k*DATA_W +: DATA_W];
    end

    // R10: no two slaves drive read data at once
    a_r10_single_driver: assert property (@(posedge clk) disable iff (rst)
        $onehot0(nz));

endmodule

// File: rtl/sbus_fanout.sv
module sbus_fanout #(
    parameter int ADDR_W  = 8,
    parameter int DATA_W  = 16,
    parameter int SEL_W   = 2,
    parameter int NUM_SLV = 3,
    parameter int REG_AW  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] m_addr,
    input  logic              m_wr,
    input  logic [DATA_W-1:0] m_wdata,
    input  logic              m_rd,
    output logic [DATA_W-1:0] m_rdata
);
    localparam int LOC_W = ADDR_W - SEL_W;

    logic [NUM_SLV-1:0]        s_wr;
    logic [NUM_SLV-1:0]        s_rd;
    logic [LOC_W-1:0]          s_addr;
    logic [DATA_W-1:0]         s_wdata;
    logic [NUM_SLV*DATA_W-1:0] slv_rdata;

    sbus_decode #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SEL_W(SEL_W), .NUM_SLV(NUM_SLV)
    ) u_decode (
        .clk(clk), .rst(rst),
        .m_addr(m_addr), .m_wr(m_wr), .m_rd(m_rd), .m_wdata(m_wdata),
        .s_wr(s_wr), .s_rd(s_rd), .s_addr(s_addr), .s_wdata(s_wdata)
    );

    for (genvar k = 0; k < NUM_SLV; k++) begin : g_slv
        sbus_regslave #(
            .LOC_W(LOC_W), .DATA_W(DATA_W), .DEPTH_AW(REG_AW)
        ) u_regs (
            .clk(clk), .rst(rst),
            .wr(s_wr[k]), .rd(s_rd[k]),
            .addr(s_addr), .wdata(s_wdata),
            .rdata(slv_rdata[k*DATA_W +: DATA_W])
        );
    end

    sbus_or_combine #(
        .NUM_SLV(NUM_SLV), .DATA_W(DATA_W)
    ) u_merge (
        .clk(clk), .rst(rst),
        .slv_rdata(slv_rdata),
        .merged(m_rdata)
    );

endmodule

// File: tb/sbus_fanout_tb.sv
`timescale 1ns/1ps
module sbus_fanout_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  m_addr = '0;
    logic        m_wr = 1'b0;
    logic [15:0] m_wdata = '0;
    logic        m_rd = 1'b0;
    logic [15:0] m_rdata;

    always #2.5 clk = ~clk;

    sbus_fanout dut_i (
        .clk(clk), .rst(rst),
        .m_addr(m_addr), .m_wr(m_wr), .m_wdata(m_wdata),
        .m_rd(m_rd), .m_rdata(m_rdata)
    );

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;
    logic [15:0] model [3][16];
    logic [31:0] seed = 32'h1234_5678;

    task automatic check(input logic [15:0] act, input logic [15:0] expv, input string tag);
        n_checks++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s: m_rdata=%h expected=%h at %0t", tag, act, expv, $time);
        end
    endtask

    function automatic bit is_mapped(input logic [7:0] a);
        return (a[7:6] < 2'd3) && (a[5:4] == 2'b00);
    endfunction

    // One bus cycle: drive at the falling edge, let one rising edge pass,
    // compare the returned data at the following falling edge.
    task automatic step(input logic w, input logic r, input logic [7:0] a,
                        input logic [15:0] d, input string tag);
        logic [15:0] expv;
        expv = (r && is_mapped(a)) ? model[a[7:6]][a[3:0]] : 16'h0000;
        m_addr = a; m_wr = w; m_rd = r; m_wdata = d;
        @(posedge clk);
        if (w && is_mapped(a)) model[a[7:6]][a[3:0]] = d;
        @(negedge clk);
        m_wr = 1'b0; m_rd = 1'b0;
        check(m_rdata, expv, tag);
    endtask

    function automatic logic [15:0] pat(input int k, input int r);
        return 16'(16'h1000 * (k + 1) + r * 17 + 16'h0A00);
    endfunction

    function automatic logic [31:0] nxt(input logic [31:0] s);
        logic [31:0] t;
        t = s ^ (s << 13);
        t = t ^ (t >> 17);
        t = t ^ (t << 5);
        return t;
    endfunction

    initial begin
        for (int k = 0; k < 3; k++)
            for (int r = 0; r < 16; r++) model[k][r] = 16'h0000;

        // R8: write attempted while reset is held
        @(negedge clk);
        m_addr = 8'h05; m_wr = 1'b1; m_wdata = 16'hFFFF; m_rd = 1'b1;
        repeat (3) @(negedge clk);
        check(m_rdata, 16'h0000, "R1");
        m_wr = 1'b0; m_rd = 1'b0;
        rst = 1'b0;

        step(1'b0, 1'b1, 8'h05, 16'h0, "R8");
        for (int k = 0; k < 3; k++)
            for (int r = 0; r < 16; r += 5)
                step(1'b0, 1'b1, {2'(k), 2'b00, 4'(r)}, 16'h0, "R1");

        // R2 / R4: fill every register, read data stays zero while writing
        for (int k = 0; k < 3; k++)
            for (int r = 0; r < 16; r++)
                step(1'b1, 1'b0, {2'(k), 2'b00, 4'(r)}, pat(k, r), "R4");

        // R2 / R9: read everything back
        for (int r = 0; r < 16; r++)
            for (int k = 0; k < 3; k++)
                step(1'b0, 1'b1, {2'(k), 2'b00, 4'(r)}, 16'h0, (k == 0) ? "R2" : "R9");

        // R5: unmapped window, then confirm slaves untouched
        for (int r = 0; r < 16; r += 3) begin
            step(1'b1, 1'b0, {2'd3, 2'b00, 4'(r)}, 16'hDEAD, "R5");
            step(1'b0, 1'b1, {2'd3, 2'b00, 4'(r)}, 16'h0, "R5");
        end
        for (int k = 0; k < 3; k++) step(1'b0, 1'b1, {2'(k), 6'h00}, 16'h0, "R5");

        // R6: beyond register depth aliases nothing
        for (int h = 1; h < 4; h++) begin
            step(1'b1, 1'b0, {2'd1, 2'(h), 4'd7}, 16'hBEEF, "R6");
            step(1'b0, 1'b1, {2'd1, 2'(h), 4'd7}, 16'h0, "R6");
        end
        step(1'b0, 1'b1, {2'd1, 2'b00, 4'd7}, 16'h0, "R6");

        // R7: combined strobes read the old value
        for (int k = 0; k < 3; k++) begin
            step(1'b1, 1'b1, {2'(k), 2'b00, 4'd9}, 16'h5A00 + 16'(k), "R7");
            step(1'b0, 1'b1, {2'(k), 2'b00, 4'd9}, 16'h0, "R7");
        end

        // R3 / R10: back-to-back reads hopping between slaves, then idle
        for (int r = 0; r < 8; r++)
            step(1'b0, 1'b1, {2'(r % 3), 2'b00, 4'(r)}, 16'h0, (r % 2) ? "R3" : "R10");
        step(1'b0, 1'b0, 8'h00, 16'h0, "R4");

        // mixed pseudo-random traffic
        for (int i = 0; i < 600; i++) begin
            logic [7:0] a;
            string tg;
            seed = nxt(seed);
            a = {seed[9:8], (seed[10] & seed[11]) ? seed[13:12] : 2'b00, seed[3:0]};
            if (!seed[17])               tg = "R4";
            else if (a[7:6] == 2'd3)     tg = "R5";
            else if (a[5:4] != 2'b00)    tg = "R6";
            else if (seed[16])           tg = "R7";
            else                         tg = "R3";
            step(seed[16], seed[17], a, seed[31:16], tg);
        end

        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        #(200000 * 5.0);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

endmodule